// File: doc/BRIEF.md
# Metastability-Emulating Capture Register

This block stands in for the receiving flip-flop of a single-bit clock-domain crossing when a design is run in emulation or simulation. It runs entirely on one fast reference clock. The receive clock's rising edge arrives as a one-tick strobe, and the receive period is a fixed whole number of reference ticks. Around every receive edge the block opens a metastability window: it opens a setup interval before the edge and closes a hold interval after it. While the window is open, the block watches the asynchronous input for changes. A change seen there is recorded as a violation. If the inject-enable input is high, the block then loads the complement of the data instead of the true sample, so that downstream logic sees the value a metastable flop could settle to.

A small phase state machine tracks the position inside the receive period. Its states are WAIT, HOLD, OPEN and SETUP. WAIT is entered from reset and left for HOLD on the first strobe. HOLD is the hold part of the window, entered on every strobe, and moves to OPEN after the hold ticks have run. OPEN is the quiet middle of the period and moves to SETUP when the setup interval before the expected edge begins. SETUP is the setup part of the window and lasts until the next strobe returns the machine to HOLD. The window output is high in HOLD and SETUP. A wide crossing uses one instance per bit, and each bit decides its own injection.

Top module: `meta_capture_reg`

## Requirements
- R1: A synchronous active-high reset clears the captured bit, the violation flag and the injection pulse, and forces the window low.
- R2: After reset the window stays low until the first receive strobe. Input changes before that strobe raise no violation and cause no injection.
- R3: The window is high for S ticks before each receive edge and for H ticks after it. S = ceil(N*SETUP_PCT/100) and H = ceil(N*HOLD_PCT/100), each at least 1. With N=16, 25 % and 10 %, this gives S=4 and H=2. Counting ticks k=1..16 after a strobe, the window is high after tick k for k<2 and for k>=12.
- R4: A change of the input counts as a violation only when the window was high over the tick that precedes it. The tick on which the window opens is excluded, and the tick on which it closes is included. Changes outside the window leave the violation flag low.
- R5: The violation flag rises on the tick after the offending change, stays high, and is cleared by the next receive strobe. This applies to setup and hold violations alike. A change on the strobe tick itself leaves the flag low.
- R6: When there is no setup violation, or when inject-enable is low, the captured bit takes the input value present at the receive strobe.
- R7: A setup violation seen at the strobe tick itself or earlier in the setup part, with inject-enable high at the strobe, makes the capture load the complement of the input.
- R8: A hold violation with inject-enable high sets the captured bit, on the tick after the violation, to the complement of the last ideal sample. This happens only if no inverted capture has yet occurred in that receive cycle.
- R9: With inject-enable low, violations are still flagged, but the captured bit always follows the ideal sample.
- R10: The injection pulse is high for exactly the one tick after each inverted load and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_stb | input | 1 | One-tick strobe marking a receive clock rising edge |
| d_in | input | 1 | Asynchronous data bit crossing into the receive domain |
| inj_en | input | 1 | Allows an inverted capture when a violation is seen |
| q_out | output | 1 | Captured bit |
| win_out | output | 1 | Metastability window, high in the setup and hold parts |
| viol_out | output | 1 | Violation flag for the current receive cycle |
| inj_pulse | output | 1 | One-tick pulse after each inverted load |

## Verification
Two functions can fall in the same tick. One is detecting a setup violation. The other is the receive-edge capture that the violation must steer. This is provoked by toggling the input on the strobe tick itself. The bench expects the complement of the new value in the captured bit, an injection pulse, and a violation flag that stays low. A second overlap is a hold violation arriving just after an inverted capture. It is judged by expecting no second injection and an unchanged captured bit.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

    typedef enum logic [1:0] {
        PH_WAIT  = 2'd0,
        PH_HOLD  = 2'd1,
        PH_OPEN  = 2'd2,
        PH_SETUP = 2'd3
    } ph_state_t;

    // Number of reference ticks covering pct percent of a period, rounded up, at least one.
    function automatic int pct_ticks(input int period, input int pct);
        int t;
        t = (period * pct + 99) / 100;
        if (t < 1) t = 1;
        return t;
    endfunction

endpackage

// File: rtl/mcr_phase.sv
module mcr_phase
    import mcr_pkg::*;
#(
    parameter int RX_TICKS = 16,
    parameter int SETUP_TK = 4,
    parameter int HOLD_TK  = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      rx_stb,
    output ph_state_t state,
    output logic      win,
    output logic      in_setup,
    output logic      in_hold
);

    localparam int CW = (RX_TICKS > 2) ? $clog2(RX_TICKS) : 1;
    localparam logic [CW-1:0] PH_LAST  = CW'(RX_TICKS - 1);
    localparam logic [CW-1:0] HOLD_END = CW'(HOLD_TK - 1);
    localparam logic [CW-1:0] OPEN_END = CW'(RX_TICKS - SETUP_TK - 1);

    logic [CW-1:0] ph;
    ph_state_t     state_nxt;

    // Ticks elapsed since the last strobe, saturating at the period end.
    always_ff @(posedge clk) begin
        if (rst) begin
            ph <= '0;
        end else if (rx_stb) begin
            ph <= '0;
        end else if (ph != PH_LAST) begin
            ph <= ph + 1'b1;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            PH_WAIT:  if (rx_stb) state_nxt = PH_HOLD;
            PH_HOLD:  if (rx_stb) state_nxt = PH_HOLD;
                      else if (ph == HOLD_END) state_nxt = PH_OPEN;
            PH_OPEN:  if (rx_stb) state_nxt = PH_HOLD;
                      else if (ph == OPEN_END) state_nxt = PH_SETUP;
            PH_SETUP: if (rx_stb) state_nxt = PH_HOLD;
            default:  state_nxt = PH_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= PH_WAIT;
        else     state <= state_nxt;
    end

    always_comb begin
        in_setup = 1'b0;
        in_hold  = 1'b0;
        unique case (state)
            PH_WAIT:  ;
            PH_HOLD:  in_hold  = 1'b1;
            PH_OPEN:  ;
            PH_SETUP: in_setup = 1'b1;
            default:  ;
        endcase
        win = in_setup | in_hold;
    end

endmodule

// File: rtl/mcr_detect.sv
module mcr_detect (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    input  logic in_setup,
    input  logic in_hold,
    output logic evt_setup,
    output logic evt_hold
);

    logic d_prev;
    logic moved;

    always_ff @(posedge clk) begin
        if (rst) d_prev <= d_in;
        else     d_prev <= d_in;
    end

    always_comb begin
        moved     = d_in ^ d_prev;
        evt_setup = moved & in_setup;
        evt_hold  = moved & in_hold;
    end

endmodule

// File: rtl/mcr_capture.sv
module mcr_capture (
    input  logic clk,
    input  logic rst,
    input  logic rx_stb,
    input  logic d_in,
    input  logic inj_en,
    input  logic evt_setup,
    input  logic evt_hold,
    output logic q,
    output logic viol,
    output logic pulse
);

    logic sflag, hflag, inj_done, ideal;
    logic sel_edge, hold_go, mux_out;

    always_comb begin
        sel_edge = inj_en & (sflag | evt_setup);
        hold_go  = inj_en & evt_hold & ~inj_done & ~rx_stb;
        mux_out  = sel_edge ? ~d_in : d_in;
        viol     = sflag | hflag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sflag    <= 1'b0;
            hflag    <= 1'b0;
            inj_done <= 1'b0;
            ideal    <= 1'b0;
            q        <= 1'b0;
            pulse    <= 1'b0;
        end else if (rx_stb) begin
            ideal    <= d_in;
            q        <= mux_out;
            pulse    <= sel_edge;
            inj_done <= sel_edge;
            sflag    <= 1'b0;
            hflag    <= 1'b0;
        end else begin
            sflag <= sflag | evt_setup;
            hflag <= hflag | evt_hold;
            pulse <= hold_go;
            if (hold_go) begin
                q        <= ~ideal;
                inj_done <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/meta_capture_reg.sv
module meta_capture_reg
    import mcr_pkg::*;
#(
    parameter int RX_TICKS  = 16,
    parameter int SETUP_PCT = 25,
    parameter int HOLD_PCT  = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_stb,
    input  logic d_in,
    input  logic inj_en,
    output logic q_out,
    output logic win_out,
    output logic viol_out,
    output logic inj_pulse
);

    localparam int SETUP_TK = pct_ticks(RX_TICKS, SETUP_PCT);
    localparam int HOLD_TK  = pct_ticks(RX_TICKS, HOLD_PCT);

    ph_state_t state;
    logic      in_setup, in_hold, evt_setup, evt_hold;

    mcr_phase #(
        .RX_TICKS(RX_TICKS),
        .SETUP_TK(SETUP_TK),
        .HOLD_TK (HOLD_TK)
    ) u_phase (
        .clk     (clk),
        .rst     (rst),
        .rx_stb  (rx_stb),
        .state   (state),
        .win     (win_out),
        .in_setup(in_setup),
        .in_hold (in_hold)
    );

    mcr_detect u_detect (
        .clk      (clk),
        .rst      (rst),
        .d_in     (d_in),
        .in_setup (in_setup),
        .in_hold  (in_hold),
        .evt_setup(evt_setup),
        .evt_hold (evt_hold)
    );

    mcr_capture u_capture (
        .clk      (clk),
        .rst      (rst),
        .rx_stb   (rx_stb),
        .d_in     (d_in),
        .inj_en   (inj_en),
        .evt_setup(evt_setup),
        .evt_hold (evt_hold),
        .q        (q_out),
        .viol     (viol_out),
        .pulse    (inj_pulse)
    );

endmodule

// File: rtl/mcr_checker.sv
module mcr_checker #(
    parameter int WIN_TK = 6
) (
    input logic clk,
    input logic rst,
    input logic rx_stb,
    input logic d_in,
    input logic inj_en,
    input logic q_out,
    input logic win_out,
    input logic viol_out,
    input logic inj_pulse
);

    logic        seen;
    logic [15:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen <= 1'b0;
            run  <= '0;
        end else begin
            if (rx_stb) seen <= 1'b1;
            run <= win_out ? run + 16'd1 : 16'd0;
        end
    end

    a_r2_win_before_strobe: assert property (@(posedge clk) disable iff (rst)
        !seen |-> !win_out);

    a_r3_win_length: assert property (@(posedge clk) disable iff (rst)
        win_out |-> (run < 16'(WIN_TK)));

    a_r5_viol_cleared: assert property (@(posedge clk) disable iff (rst)
        rx_stb |=> !viol_out);

    a_r6_ideal_capture: assert property (@(posedge clk) disable iff (rst)
        (rx_stb && !inj_en) |=> (q_out == $past(d_in)));

    a_r9_no_inject_when_off: assert property (@(posedge clk) disable iff (rst)
        !inj_en |=> !inj_pulse);

    a_r10_pulse_single: assert property (@(posedge clk) disable iff (rst)
        inj_pulse |=> !inj_pulse);

    a_r10_q_moves_only_on_load: assert property (@(posedge clk) disable iff (rst)
        !$stable(q_out) |-> ($past(rx_stb) || inj_pulse));

endmodule

bind meta_capture_reg mcr_checker #(
    .WIN_TK(SETUP_TK + HOLD_TK)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rx_stb   (rx_stb),
    .d_in     (d_in),
    .inj_en   (inj_en),
    .q_out    (q_out),
    .win_out  (win_out),
    .viol_out (viol_out),
    .inj_pulse(inj_pulse)
);

// File: tb/tb_meta_capture_reg.sv
module tb_meta_capture_reg;

    localparam int N = 16;
    localparam int S = 4;   // R3: ceil(16*25/100)
    localparam int H = 2;   // R3: ceil(16*10/100)

    logic clk = 1'b0;
    logic rst, rx_stb, d_in, inj_en;
    logic q_out, win_out, viol_out, inj_pulse;

    int total = 0;
    int bad   = 0;
    bit q_model, last_sel;

    always #4 clk = ~clk;

    meta_capture_reg #(.RX_TICKS(N), .SETUP_PCT(25), .HOLD_PCT(10)) dut (
        .clk(clk), .rst(rst), .rx_stb(rx_stb), .d_in(d_in), .inj_en(inj_en),
        .q_out(q_out), .win_out(win_out), .viol_out(viol_out), .inj_pulse(inj_pulse)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(input bit stb);
        rx_stb = stb;
        @(posedge clk);
        #2;
        rx_stb = 1'b0;
    endtask

    // R1: reset state
    task automatic t_reset();
        rst = 1'b1;
        repeat (3) tick(1'b0);
        check("R1 q", q_out, 0);
        check("R1 viol", viol_out, 0);
        check("R1 pulse", inj_pulse, 0);
        check("R1 win", win_out, 0);
        rst = 1'b0;
        q_model = 1'b0;
        last_sel = 1'b0;
    endtask

    // R2: no window and no violation before the first strobe
    task automatic t_wait(input int ticks);
        for (int i = 0; i < ticks; i++) begin
            d_in = ~d_in;
            inj_en = 1'b1;
            tick(1'b0);
            check("R2 win", win_out, 0);
            check("R2 viol", viol_out, 0);
            check("R2 pulse", inj_pulse, 0);
        end
    endtask

    task automatic t_first_strobe();
        d_in = 1'b1;
        inj_en = 1'b1;
        tick(1'b1);
        check("R2 q", q_out, 1);
        check("R2 win", win_out, 1);
        q_model = 1'b1;
        last_sel = 1'b0;
    endtask

    // One receive period: optional toggle of d_in at tick chg (0 = none)
    task automatic run_cycle(input int chg, input bit en, input string tag);
        bit prev_ideal, in_s, in_h, sel, pulse_exp, viol_exp, win_exp;
        prev_ideal = d_in;
        in_s = (chg >= N - S + 1) && (chg <= N);   // R4: opening tick excluded
        in_h = (chg >= 1) && (chg <= H);           // R4: closing tick included
        for (int k = 1; k <= N; k++) begin
            if (k == chg) d_in = ~d_in;
            inj_en = en;
            tick(k == N);
            win_exp = (k < H) || (k >= N - S);
            pulse_exp = 1'b0;
            if (k < N) begin
                viol_exp = (in_s || in_h) && (k >= chg);
                if (in_h && en && k == chg && !last_sel) begin
                    q_model = ~prev_ideal;
                    pulse_exp = 1'b1;
                end
            end else begin
                viol_exp = 1'b0;
                sel = en && in_s;
                q_model = sel ? ~d_in : d_in;
                pulse_exp = sel;
                last_sel = sel;
            end
            check({tag, " R3 win"}, win_out, win_exp);
            check({tag, " R5 viol"}, viol_out, viol_exp);
            check({tag, " R10 pulse"}, inj_pulse, pulse_exp);
            check({tag, " q"}, q_out, q_model);
        end
    endtask

    task automatic t_midreset();
        for (int i = 0; i < 5; i++) tick(1'b0);
        rst = 1'b1;
        tick(1'b0);
        check("R1 q", q_out, 0);
        check("R1 viol", viol_out, 0);
        check("R1 win", win_out, 0);
        rst = 1'b0;
        t_wait(20);
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; rx_stb = 1'b0; d_in = 1'b0; inj_en = 1'b0;
        t_reset();
        t_wait(10);
        t_first_strobe();
        run_cycle(0,  1'b1, "R3");
        run_cycle(6,  1'b1, "R6");   // mid-period change, ideal capture
        run_cycle(12, 1'b1, "R4");   // opening tick excluded
        run_cycle(3,  1'b1, "R4");   // tick after closing excluded
        run_cycle(2,  1'b1, "R8");   // closing tick, hold injection
        run_cycle(14, 1'b1, "R7");   // setup injection
        run_cycle(1,  1'b1, "R8");   // hold after inverted capture: blocked
        run_cycle(16, 1'b1, "R7");   // change on the strobe tick
        run_cycle(13, 1'b0, "R9");   // setup, injection off
        run_cycle(1,  1'b0, "R9");   // hold, injection off
        run_cycle(13, 1'b1, "R7");   // first setup tick
        run_cycle(0,  1'b0, "R6");
        run_cycle(1,  1'b1, "R8");   // hold injection
        t_midreset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule